// File: doc/BRIEF.md
# Windowed Pixel Histogram Accumulator

This block builds a histogram of pixel values over one rectangle of a streamed image frame. Each Bayer color gets its own histogram. A pixel arrives with a valid qualifier and two active flags, one for the line and one for the frame. The block counts columns and rows inside the active area. Each qualifying pixel inside the programmed window adds one to the bin picked by its color and the upper bits of its value. Every counter saturates at its top value and does not wrap.

All bins clear when a new frame begins. A one-cycle done flag is raised once the frame ends. After that, software or a downstream engine reads the bins back one at a time through a synchronous read port. The window is set through two 32-bit configuration words. Width and height are written minus one, and a value of zero stretches the window to the end of the line or to the bottom of the frame. The pixel stream has no back-pressure: the block accepts a pixel in every cycle that `pix_valid` is high, and there is no ready signal. The read port also cannot stall, and it returns data exactly one cycle after the request.

Top module: `pix_hist_acc`

## Requirements
- R1: After reset, every bin reads 0, `frame_done` is low and `rd_valid` is low.
- R2: A write with `cfg_sel`=0 loads the window left from `cfg_wdata[15:0]` and the window top from `cfg_wdata[31:16]`. A write with `cfg_sel`=1 loads width minus one from `cfg_wdata[15:0]` and height minus one from `cfg_wdata[31:16]`.
- R3: Columns count from 0 for each accepted pixel in a line. Rows count from 0 and advance when `pix_hact` falls. A pixel is counted only when left <= column <= left+width_m1 and top <= row <= top+height_m1, with both bounds inclusive.
- R4: A width_m1 of 0 removes the right bound, so the window runs to the end of the active line. A height_m1 of 0 removes the bottom bound, so the window runs to the end of the active frame.
- R5: The bin address is {row[0], column[0], pix_data[PIX_W-1 -: BIN_BITS]}. Bits [BIN_BITS+1:BIN_BITS] of `rd_addr` select the color and the low BIN_BITS bits select the bin.
- R6: Each bin is a CNT_W-bit counter (18 by default) that holds at its all-ones value and never wraps.
- R7: In the cycle where `pix_vact` is first seen high, all bins clear. A pixel accepted in that same cycle still counts as 1.
- R8: `frame_done` is high for exactly one cycle: the cycle after the first clock edge that samples `pix_vact` low following a high.
- R9: A read issued with `rd_en` at one clock edge returns the bin on `rd_data` with `rd_valid` high after the next edge. `rd_valid` is low after any edge where `rd_en` was low.
- R10: When a read and an increment hit the same bin in the same cycle, the read returns the value before the increment.
- R11: Cycles with `pix_valid` low or `pix_hact` low count nothing and do not advance the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel qualifier |
| pix_hact | input | 1 | Line active flag |
| pix_vact | input | 1 | Frame active flag |
| pix_data | input | PIX_W | Pixel value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: left/top word, 1: width/height-minus-one word |
| cfg_wdata | input | 32 | Configuration data |
| rd_en | input | 1 | Bin read request |
| rd_addr | input | BIN_BITS+2 | {color, bin} to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W | Bin count |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions check some properties on every cycle. They confirm that the done pulse lasts one cycle and follows a falling frame flag. They confirm that read data is valid exactly one cycle after each request. They also confirm that the window never admits a column left of its margin. Other behaviours can only be shown by the bench scenarios, which compare every bin against a model after each frame. These cover inclusive window bounds, the open-ended window for zero sizes, color and bin addressing, saturation, clearing between frames, skipped invalid cycles, and read-before-write ordering.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int COORD_W = 16;
  typedef logic [COORD_W-1:0] coord_t;
  typedef struct packed {
    coord_t hm1;
    coord_t wm1;
    coord_t top;
    coord_t left;
  } win_cfg_t;
endpackage

// File: rtl/hist_scan.sv
module hist_scan
  import hist_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pix_valid,
  input  logic   hact,
  input  logic   vact,
  output coord_t col,
  output coord_t row,
  output logic   frame_start,
  output logic   frame_end
);
  logic hact_q, vact_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hact_q <= 1'b0;
      vact_q <= 1'b0;
      col    <= '0;
      row    <= '0;
    end else begin
      hact_q <= hact;
      vact_q <= vact;
      if (!vact)                row <= '0;
      else if (hact_q && !hact) row <= row + 1'b1;
      if (!hact || !vact)       col <= '0;
      else if (pix_valid)       col <= col + 1'b1;
    end
  end

  assign frame_start = vact & ~vact_q;
  assign frame_end   = vact_q & ~vact;
endmodule

// File: rtl/hist_window.sv
module hist_window
  import hist_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  coord_t      col,
  input  coord_t      row,
  output win_cfg_t    cfg,
  output logic        in_win
);
  logic [COORD_W:0] x_end, y_end;
  logic             x_ok, y_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) begin
        cfg.wm1 <= cfg_wdata[15:0];
        cfg.hm1 <= cfg_wdata[31:16];
      end else begin
        cfg.left <= cfg_wdata[15:0];
        cfg.top  <= cfg_wdata[31:16];
      end
    end
  end

  always_comb begin
    x_end  = {1'b0, cfg.left} + {1'b0, cfg.wm1};
    y_end  = {1'b0, cfg.top} + {1'b0, cfg.hm1};
    x_ok   = (col >= cfg.left) && ((cfg.wm1 == '0) || ({1'b0, col} <= x_end));
    y_ok   = (row >= cfg.top)  && ((cfg.hm1 == '0) || ({1'b0, row} <= y_end));
    in_win = x_ok && y_ok;
  end
endmodule

// File: rtl/hist_bins.sv
module hist_bins #(
  parameter int BIN_BITS = 8,
  parameter int CNT_W    = 18,
  localparam int NCOLOR  = 4,
  localparam int NPB     = 1 << BIN_BITS,
  localparam int AW      = BIN_BITS + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic [AW-1:0]    inc_addr,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] bank_rd [NCOLOR];
  logic [1:0]       rd_color_q;

  for (genvar c = 0; c < NCOLOR; c++) begin : g_bank
    logic [CNT_W-1:0] mem [NPB];
    logic             hit;
    assign hit = inc && (inc_addr[AW-1 -: 2] == 2'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NPB; i++) mem[i] <= '0;
        bank_rd[c] <= '0;
      end else begin
        if (rd_en) bank_rd[c] <= mem[rd_addr[BIN_BITS-1:0]];
        if (clear) begin
          for (int i = 0; i < NPB; i++)
            mem[i] <= (hit && inc_addr[BIN_BITS-1:0] == BIN_BITS'(i)) ? CNT_W'(1) : '0;
        end else if (hit && mem[inc_addr[BIN_BITS-1:0]] != CNT_MAX) begin
          mem[inc_addr[BIN_BITS-1:0]] <= mem[inc_addr[BIN_BITS-1:0]] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_color_q <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_color_q <= rd_addr[AW-1 -: 2];
    end
  end

  assign rd_data = bank_rd[rd_color_q];
endmodule

// File: rtl/pix_hist_acc.sv
module pix_hist_acc
  import hist_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int BIN_BITS = 8,
  parameter int CNT_W    = 18,
  localparam int AW      = BIN_BITS + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             pix_hact,
  input  logic             pix_vact,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             frame_done
);
  coord_t   col, row;
  logic     frame_start, frame_end, in_win, inc;
  logic [AW-1:0] inc_addr;
  win_cfg_t win_cfg;

  hist_scan u_scan (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .hact(pix_hact), .vact(pix_vact),
    .col(col), .row(row), .frame_start(frame_start), .frame_end(frame_end)
  );

  hist_window u_win (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .col(col), .row(row), .cfg(win_cfg), .in_win(in_win)
  );

  assign inc      = pix_valid && pix_hact && pix_vact && in_win;
  assign inc_addr = {row[0], col[0], pix_data[PIX_W-1 -: BIN_BITS]};

  hist_bins #(.BIN_BITS(BIN_BITS), .CNT_W(CNT_W)) u_bins (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .inc(inc), .inc_addr(inc_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_done <= 1'b0;
    else        frame_done <= frame_end;
  end
endmodule

// File: rtl/pix_hist_acc_chk.sv
module pix_hist_acc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_vact,
  input logic        frame_done,
  input logic        rd_en,
  input logic        rd_valid,
  input logic        in_win,
  input logic [15:0] col,
  input logic [15:0] left
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_done_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!$past(pix_vact) && $past(pix_vact, 2)));
  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_window_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (col >= left));
endmodule

bind pix_hist_acc pix_hist_acc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_vact(pix_vact), .frame_done(frame_done),
  .rd_en(rd_en), .rd_valid(rd_valid), .in_win(in_win), .col(col), .left(win_cfg.left)
);

// File: tb/test_pix_hist_acc.sv
module test_pix_hist_acc;
  localparam int PIX_W = 12, BIN_BITS = 8, CNT_W = 6, AW = BIN_BITS + 2;
  localparam int NBINS = 4 << BIN_BITS;
  localparam int CMAX  = (1 << CNT_W) - 1;

  // vector: left, top, wm1, hm1, rows, cols, seed (seed 0 = constant pixel)
  localparam int NV = 5;
  localparam logic [111:0] VEC [NV] = '{
    {16'd0, 16'd0, 16'd0,  16'd0, 16'd6,  16'd10, 16'd1},  // R4 full frame
    {16'd2, 16'd1, 16'd3,  16'd2, 16'd8,  16'd12, 16'd2},  // R3 inner window
    {16'd5, 16'd3, 16'd0,  16'd0, 16'd7,  16'd11, 16'd3},  // R4 open-ended
    {16'd1, 16'd0, 16'd20, 16'd1, 16'd5,  16'd9,  16'd4},  // R3 beyond line
    {16'd0, 16'd0, 16'd0,  16'd0, 16'd12, 16'd24, 16'd0}   // R6 saturation
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 0, pix_hact = 0, pix_vact = 0;
  logic [PIX_W-1:0] pix_data = '0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0;
  logic rd_en = 0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_valid, frame_done;
  logic [CNT_W-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int model [NBINS];
  int w_left, w_top, w_wm1, w_hm1;
  bit finished = 0;

  always #4 clk = ~clk;

  pix_hist_acc #(.PIX_W(PIX_W), .BIN_BITS(BIN_BITS), .CNT_W(CNT_W)) i_pix_hist_acc (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_hact(pix_hact), .pix_vact(pix_vact),
    .pix_data(pix_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .frame_done(frame_done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input bit sel, input int lo, input int hi);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = {hi[15:0], lo[15:0]};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic read_bin(input int a, output int v, output bit vld);
    @(negedge clk);
    rd_en = 1; rd_addr = a[AW-1:0];
    @(negedge clk);
    rd_en = 0; v = int'(rd_data); vld = rd_valid;
  endtask

  function automatic int pix_of(input int r, input int c, input int seed);
    if (seed == 0) return 'h5A0;
    return ((r * 7 + c * 13 + seed * 29) * 41) % 4096;
  endfunction

  task automatic run_frame(input int rows, input int cols, input int seed);
    for (int i = 0; i < NBINS; i++) model[i] = 0;
    @(negedge clk); pix_vact = 1;
    @(negedge clk);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < cols; c++) begin
        if (c == 3) begin  // R11: idle cycle inside the line, value must not count
          @(negedge clk); pix_hact = 1; pix_valid = 0; pix_data = 12'hFFF;
        end
        @(negedge clk);
        pix_hact = 1; pix_valid = 1; pix_data = pix_of(r, c, seed)[PIX_W-1:0];
        if (c >= w_left && (w_wm1 == 0 || c <= w_left + w_wm1) &&
            r >= w_top && (w_hm1 == 0 || r <= w_top + w_hm1)) begin
          int a = ((r & 1) * 2 + (c & 1)) * 256 + (pix_of(r, c, seed) >> 4);
          if (model[a] < CMAX) model[a]++;
        end
      end
      @(negedge clk); pix_hact = 0; pix_valid = 0;
      @(negedge clk);
    end
    @(negedge clk); pix_vact = 0;
    @(negedge clk); check("R8 done high", int'(frame_done), 1);
    @(negedge clk); check("R8 done one cycle", int'(frame_done), 0);
  endtask

  task automatic compare_all(input string req);
    int v; bit vld;
    for (int a = 0; a < NBINS; a++) begin
      read_bin(a, v, vld);
      if (v != model[a] || !vld) check(req, v, model[a]);
      else n_chk++;
    end
  endtask

  initial begin
    int v; bit vld;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done low", int'(frame_done), 0);
    check("R1 rd_valid low", int'(rd_valid), 0);
    rst_n = 1;
    for (int a = 0; a < NBINS; a += 97) begin
      read_bin(a, v, vld);
      check("R1 bin zero", v, 0);
      check("R9 rd_valid", int'(vld), 1);
    end
    @(negedge clk);
    check("R9 rd_valid drops", int'(rd_valid), 0);

    // table of vectors (R2 R3 R4 R5 R6 R7 R11)
    for (int k = 0; k < NV; k++) begin
      w_left = int'(VEC[k][111:96]); w_top = int'(VEC[k][95:80]);
      w_wm1  = int'(VEC[k][79:64]);  w_hm1 = int'(VEC[k][63:48]);
      write_cfg(0, w_left, w_top);   // R2
      write_cfg(1, w_wm1, w_hm1);
      run_frame(int'(VEC[k][47:32]), int'(VEC[k][31:16]), int'(VEC[k][15:0]));
      compare_all("R5 bins vs model");
    end
    // R6: saturation reached in last vector, bin of color 0 value 0x5A0
    read_bin(90, v, vld);
    check("R6 saturated", v, CMAX);

    // R10 read-before-write, R7 clear at frame start
    write_cfg(0, 0, 0); write_cfg(1, 0, 0);
    @(negedge clk); pix_vact = 1;
    @(negedge clk); pix_hact = 1; pix_valid = 1; pix_data = 12'h330;  // col0 color0
    @(negedge clk); pix_data = 12'h330;                                // col1 color1
    @(negedge clk); pix_data = 12'h330; rd_en = 1; rd_addr = 10'h033;  // col2 color0
    @(negedge clk); rd_en = 0; pix_hact = 0; pix_valid = 0;
    check("R10 old value read", int'(rd_data), 1);
    @(negedge clk); pix_vact = 0;
    repeat (2) @(negedge clk);
    read_bin('h033, v, vld);
    check("R10 increment landed", v, 2);
    read_bin('h133, v, vld);
    check("R5 color1 bin", v, 1);
    read_bin(90, v, vld);
    check("R7 cleared", v, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule